// File: doc/BRIEF.md
# NVRAM Indirect Access Controller

This block lets a host reach a byte-wide nonvolatile memory through two byte lanes of one 32-bit register word. The top byte lane is the command/status register. The byte lane below it is the address/data register. The host writes command bytes to steer bytes from the data lane into a low or high address latch, and to start a read. It polls a busy flag and then reads the fetched byte back from the data lane.

Address bytes are staged in a holding register. A staged byte is committed only when the next recognised command changes the decode phase. If several data writes occur in one phase, the last one wins. The latched addresses are not incremented after an access and keep their values, so the host can change just one address byte before the next access. On the memory side, a request/acknowledge port carries a 16-bit address and returns one data byte.

Top module: `nvram_indirect_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0 (busy bit 31 clear, data byte 0), `mem_req` is 0, `mem_addr` is 0000h and the holding byte is 00h.
- R2: The command byte sits in `wr_data[31:24]` and is accepted when `wr_be[3]` is set. Code 80h opens the low phase and code A0h opens the high phase. Code E0h commits the held byte into the address byte of the current phase, goes back to no phase, and raises `mem_req` at `{high,low}` on the next cycle.
- R3: The data byte sits in `wr_data[23:16]` and is accepted when `wr_be[2]` is set. While a phase is open, each data write replaces the holding byte, and only the last value before a command is committed. For example, 40h then 41h gives low byte 41h.
- R4: `rd_data[31]` is 1 from the cycle after E0h until the cycle after `mem_ack`. The byte acknowledged appears in `rd_data[23:16]` and stays there until the next acknowledge.
- R5: A single write that carries both a data byte and a command applies the data byte to the holding byte before the commit.
- R6: Address bytes keep their values after a read and never increment. Updating one byte leaves the other byte unchanged.
- R7: Commands and data writes made while busy is set are ignored.
- R8: A command byte other than 80h, A0h or E0h leaves the phase, the holding byte and both address bytes unchanged.
- R9: `mem_req` stays high with a stable `mem_addr` until `mem_ack` is seen.
- R10: Data writes made while no phase is open (after reset or after E0h) do not change the holding byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe |
| wr_be | input | 4 | Byte enables of the host write |
| wr_data | input | 32 | Host write word: command in [31:24], data in [23:16] |
| rd_data | output | 32 | Status and data word: busy in [31], fetched byte in [23:16] |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_ack | input | 1 | One-cycle read acknowledge |
| mem_rdata | input | 8 | Byte returned with the acknowledge |

## Verification
The hardest state to reach from the ports is the holding byte when it is not followed straight away by a commit. It is only visible after a later command commits it. The bench therefore issues a data write while no phase is open, then opens a phase and commits without writing any new data. The address that results must show the older, in-phase value. The bench also sends combined data-plus-command words while moving between phases, so that the ordering of the staged byte against the commit shows up on `mem_addr`.

// File: rtl/nvram_indirect_ctrl.sv
module nvram_indirect_ctrl #(
  parameter logic [7:0] CMD_LO = 8'h80,
  parameter logic [7:0] CMD_HI = 8'hA0,
  parameter logic [7:0] CMD_RD = 8'hE0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  input  logic        mem_ack,
  input  logic [7:0]  mem_rdata
);
  localparam int CTL_LSB = 24;
  localparam int DAT_LSB = 16;

  typedef enum logic [1:0] {PH_NONE, PH_LOW, PH_HIGH} phase_t;

  phase_t     phase;
  logic       busy;
  logic [7:0] hold, addr_lo, addr_hi, fetched;

  wire [7:0] cmd    = wr_data[CTL_LSB +: 8];
  wire [7:0] din    = wr_data[DAT_LSB +: 8];
  wire       cmd_wr = wr_en & wr_be[CTL_LSB/8] & ~busy;
  wire       dat_wr = wr_en & wr_be[DAT_LSB/8] & ~busy & (phase != PH_NONE);
  wire       cmd_ok = cmd_wr & ((cmd == CMD_LO) | (cmd == CMD_HI) | (cmd == CMD_RD));
  wire [7:0] hold_nx = dat_wr ? din : hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_NONE;
      busy    <= 1'b0;
      hold    <= '0;
      addr_lo <= '0;
      addr_hi <= '0;
      fetched <= '0;
    end else begin
      hold <= hold_nx;
      if (cmd_ok) begin
        if (phase == PH_LOW)  addr_lo <= hold_nx;
        if (phase == PH_HIGH) addr_hi <= hold_nx;
        if (cmd == CMD_LO)      phase <= PH_LOW;
        else if (cmd == CMD_HI) phase <= PH_HIGH;
        else begin
          phase <= PH_NONE;
          busy  <= 1'b1;
        end
      end
      if (busy && mem_ack) begin
        busy    <= 1'b0;
        fetched <= mem_rdata;
      end
    end
  end

  assign mem_req  = busy;
  assign mem_addr = {addr_hi, addr_lo};
  assign rd_data  = {busy, 7'b0, fetched, 16'b0};
endmodule

module nvram_indirect_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [3:0]  wr_be,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        mem_req,
  input logic [15:0] mem_addr,
  input logic        mem_ack
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> !mem_req && !rd_data[31]);
  // R4
  data_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_ack |=> $stable(rd_data[23:16]));
  // R2
  start_rd_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_be[3] && wr_data[31:24] == 8'hE0 && !mem_req |=> mem_req);
  // R8
  bad_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_be == 4'b1000 && wr_data[31:24] != 8'h80 && wr_data[31:24] != 8'hA0
      && wr_data[31:24] != 8'hE0 |=> $stable(mem_addr));
endmodule

bind nvram_indirect_ctrl nvram_indirect_ctrl_chk chk_i (.*);

// File: tb/nvram_indirect_ctrl_tb_top.sv
module nvram_indirect_ctrl_tb_top;
  logic        clk = 0, rst = 1, wr_en = 0, mem_ack = 0;
  logic [3:0]  wr_be = 0;
  logic [31:0] wr_data = 0;
  logic [7:0]  mem_rdata = 0;
  logic [31:0] rd_data;
  logic        mem_req;
  logic [15:0] mem_addr;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nvram_indirect_ctrl dut_i (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_be = be; wr_data = d;
    @(negedge clk); wr_en = 0; wr_be = 0;
  endtask

  task automatic ack(input logic [7:0] b);
    @(negedge clk); mem_ack = 1; mem_rdata = b;
    @(negedge clk); mem_ack = 0;
  endtask

  // {be, data, expected mem_addr}
  localparam int NV = 10;
  localparam logic [51:0] VEC [NV] = '{
    {4'b1000, 32'h8000_0000, 16'h0000},
    {4'b0100, 32'h0040_0000, 16'h0000},
    {4'b0100, 32'h0041_0000, 16'h0000},
    {4'b1000, 32'hA000_0000, 16'h0041},
    {4'b0100, 32'h0012_0000, 16'h0041},
    {4'b1000, 32'h5500_0000, 16'h0041},
    {4'b0100, 32'h0013_0000, 16'h0041},
    {4'b1000, 32'h8000_0000, 16'h1341},
    {4'b1100, 32'hA077_0000, 16'h1377},
    {4'b1100, 32'h8000_0000, 16'h0077}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 mem_req", {31'b0, mem_req}, 32'h0);
    check("R1 mem_addr", {16'b0, mem_addr}, 32'h0);

    // R3 last write wins, R8 unknown code, R5 combined writes
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][51:48], VEC[i][47:16]);
      check($sformatf("R3/R5/R8 vec%0d addr", i), {16'b0, mem_addr}, {16'b0, VEC[i][15:0]});
      check($sformatf("R2 vec%0d no req", i), {31'b0, mem_req}, 32'h0);
    end

    // R2 start read: low phase, hold 00 committed into low byte
    wr(4'b1000, 32'hE000_0000);
    check("R2 mem_req", {31'b0, mem_req}, 32'h1);
    check("R2 mem_addr", {16'b0, mem_addr}, 32'h0000_0000);
    check("R4 busy bit", {31'b0, rd_data[31]}, 32'h1);
    // R7 writes while busy ignored
    wr(4'b1000, 32'h8000_0000);
    wr(4'b1100, 32'hA055_0000);
    check("R7 addr while busy", {16'b0, mem_addr}, 32'h0);
    repeat (3) @(negedge clk);
    check("R9 req held", {31'b0, mem_req}, 32'h1);
    ack(8'h5A);
    check("R4 busy clear", {31'b0, rd_data[31]}, 32'h0);
    check("R4 data byte", {24'b0, rd_data[23:16]}, 32'h5A);
    check("R7 phase not opened", {16'b0, mem_addr}, 32'h0);

    // Full read 9D3C
    wr(4'b1000, 32'h8000_0000);
    wr(4'b0100, 32'h003C_0000);
    wr(4'b1000, 32'hA000_0000);
    wr(4'b0100, 32'h009D_0000);
    wr(4'b1000, 32'hE000_0000);
    check("R2 addr 9D3C", {16'b0, mem_addr}, 32'h9D3C);
    ack(8'hC3);
    check("R4 data C3", {24'b0, rd_data[23:16]}, 32'hC3);
    check("R6 addr kept", {16'b0, mem_addr}, 32'h9D3C);

    // R10 data write with no phase is dropped; R6 only low byte updated
    wr(4'b0100, 32'h0077_0000);
    wr(4'b1000, 32'h8000_0000);
    wr(4'b1000, 32'hA000_0000);
    check("R10/R6 addr", {16'b0, mem_addr}, 32'h9D9D);
    wr(4'b1000, 32'hE000_0000);
    check("R6 read addr", {16'b0, mem_addr}, 32'h9D9D);
    ack(8'h11);
    check("R4 data 11", {24'b0, rd_data[23:16]}, 32'h11);

    // R1 reset clears everything
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1 re-reset addr", {16'b0, mem_addr}, 32'h0);
    check("R1 re-reset rd", rd_data, 32'h0);
    // R1 holding byte cleared: open phase and commit with no data
    wr(4'b1000, 32'h8000_0000);
    wr(4'b1000, 32'hA000_0000);
    check("R1 hold cleared", {16'b0, mem_addr}, 32'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule